// File: doc/BRIEF.md
# Cascadable Presettable Synchronous Up-Counter

This block is a small synchronous up-counter with a parallel preset. It is meant for dividers, timers and programmable count sequences. Two build-time parameters choose its variant. The first picks a decade count (0 to 9) or a full binary count (0 to 15). The second decides whether the active-low clear acts at once or waits for the next rising clock edge.

The count advances only when two active-high enables are both high. One enable also gates the carry output. A chain is built by tying every stage's gating enable to the carry of the stage below. The result is a wider synchronous counter with no glue logic between stages.

An active-low load copies the preset bus into the count on the next edge and overrides both enables. Clear overrides everything else.

Top module: `presettable_counter`

## Requirements
- R1: With the immediate-clear variant (ASYNC_CLR=1), a low `clr_n` drives `count` to 0 within the same clock phase. This happens whatever the clock, `load_n` and the enables are doing.
- R2: With the edge-clear variant (ASYNC_CLR=0), a low `clr_n` leaves `count` unchanged until the next rising edge of `clk`. At that edge `count` becomes 0, even if `load_n` is low at the same time.
- R3: When `clr_n` is high and `load_n` is low at a rising edge, `count` takes the value of `preset` at that edge, whatever the enables are.
- R4: When `clr_n` and `load_n` are high and both `cnt_en` and `carry_en` are high at a rising edge, `count` increases by one.
- R5: When `clr_n` and `load_n` are high and either enable is low at a rising edge, `count` keeps its value.
- R6: The terminal value is 9 in decade mode (DECADE=1) and 15 in binary mode (DECADE=0). An enabled count at the terminal value wraps to 0 on the next edge.
- R7: `carry_out` is high exactly when `carry_en` is high and `count` equals the terminal value. It follows its inputs without waiting for a clock edge and does not depend on `cnt_en`.
- R8: In decade mode, a preset of 10 to 15 counts up through 15 and then wraps to 0. `carry_out` stays low while `count` is above 9.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Active-low clear, immediate or edge-timed per ASYNC_CLR |
| load_n | input | 1 | Active-low synchronous preset load |
| preset | input | W | Value copied into the count on a load |
| cnt_en | input | 1 | Count enable that does not affect carry |
| carry_en | input | 1 | Count enable that also gates carry_out |
| count | output | W | Present count value |
| carry_out | output | 1 | Terminal-count flag gated by carry_en, for cascading |

## Verification
A corrupted count register shows at `count` on the edge right after the bad update. It is then carried forward by every later increment, so the checker's next-value comparison flags it within one cycle. A wrong terminal decode shows as `carry_out` being high or low at the wrong value, or as a wrap at the wrong place. The bench looks for it at the values 9, 15 and the out-of-range decade presets. A mixed-up priority between clear, load and the enables shows on the first edge where two of them are active together. The bench sets up those collisions on purpose.

// File: rtl/ctr_pkg.sv
package ctr_pkg;

  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_STEP  = 2'd1,
    OP_LOAD  = 2'd2,
    OP_ZERO  = 2'd3
  } ctr_op_e;

  function automatic int unsigned term_value(input int unsigned w, input bit decade);
    term_value = decade ? 9 : ((1 << w) - 1);
  endfunction

endpackage

// File: rtl/ctr_op_decode.sv
module ctr_op_decode
  import ctr_pkg::*;
#(
  parameter bit SYNC_CLR = 1'b1
) (
  input  logic    clr_n,
  input  logic    load_n,
  input  logic    cnt_en,
  input  logic    carry_en,
  output ctr_op_e op
);

  logic both_en;
  assign both_en = cnt_en & carry_en;

  // Priority: clear (when edge-timed), load, then count.
  always_comb begin
    op = OP_HOLD;
    if (SYNC_CLR && !clr_n) begin
      op = OP_ZERO;
    end else if (!load_n) begin
      op = OP_LOAD;
    end else if (both_en) begin
      op = OP_STEP;
    end
  end

endmodule

// File: rtl/ctr_terminal.sv
module ctr_terminal #(
  parameter int unsigned W    = 4,
  parameter int unsigned TERM = 15
) (
  input  logic [W-1:0] count,
  input  logic         carry_en,
  output logic         at_term,
  output logic         carry_out
);

  localparam logic [W-1:0] TERM_V = W'(TERM);

  assign at_term   = (count == TERM_V);
  assign carry_out = carry_en & at_term;

endmodule

// File: rtl/ctr_next.sv
module ctr_next
  import ctr_pkg::*;
#(
  parameter int unsigned W = 4
) (
  input  ctr_op_e      op,
  input  logic [W-1:0] count,
  input  logic [W-1:0] preset,
  input  logic         at_term,
  output logic [W-1:0] count_nxt
);

  logic [W-1:0] incr;

  // Wrap at the terminal value; above it the natural W-bit overflow wraps.
  assign incr = at_term ? '0 : count + W'(1);

  always_comb begin
    unique case (op)
      OP_ZERO: count_nxt = '0;
      OP_LOAD: count_nxt = preset;
      OP_STEP: count_nxt = incr;
      default: count_nxt = count;
    endcase
  end

endmodule

// File: rtl/ctr_state_reg.sv
module ctr_state_reg #(
  parameter int unsigned W         = 4,
  parameter bit          ASYNC_CLR = 1'b1
) (
  input  logic         clk,
  input  logic         clr_n,
  input  logic         upd_en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  generate
    if (ASYNC_CLR) begin : g_async
      always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
          q <= '0;
        end else if (upd_en) begin
          q <= d;
        end
      end
    end else begin : g_sync
      always_ff @(posedge clk) begin
        if (upd_en) begin
          q <= d;
        end
      end
    end
  endgenerate

endmodule

// File: rtl/presettable_counter.sv
module presettable_counter
  import ctr_pkg::*;
#(
  parameter int unsigned W         = 4,
  parameter bit          DECADE    = 1'b1,
  parameter bit          ASYNC_CLR = 1'b1
) (
  input  logic         clk,
  input  logic         clr_n,
  input  logic         load_n,
  input  logic [W-1:0] preset,
  input  logic         cnt_en,
  input  logic         carry_en,
  output logic [W-1:0] count,
  output logic         carry_out
);

  localparam int unsigned TERM = term_value(W, DECADE);

  ctr_op_e      op;
  logic         at_term;
  logic         upd_en;
  logic [W-1:0] count_nxt;

  ctr_op_decode #(.SYNC_CLR(!ASYNC_CLR)) u_dec (
    .clr_n    (clr_n),
    .load_n   (load_n),
    .cnt_en   (cnt_en),
    .carry_en (carry_en),
    .op       (op)
  );

  ctr_terminal #(.W(W), .TERM(TERM)) u_term (
    .count     (count),
    .carry_en  (carry_en),
    .at_term   (at_term),
    .carry_out (carry_out)
  );

  ctr_next #(.W(W)) u_next (
    .op        (op),
    .count     (count),
    .preset    (preset),
    .at_term   (at_term),
    .count_nxt (count_nxt)
  );

  // Explicit clock enable: the register only loads on a state-changing op.
  assign upd_en = (op != OP_HOLD);

  ctr_state_reg #(.W(W), .ASYNC_CLR(ASYNC_CLR)) u_reg (
    .clk    (clk),
    .clr_n  (clr_n),
    .upd_en (upd_en),
    .d      (count_nxt),
    .q      (count)
  );

endmodule

// File: rtl/presettable_counter_chk.sv
module presettable_counter_chk #(
  parameter int unsigned W         = 4,
  parameter bit          DECADE    = 1'b1,
  parameter bit          ASYNC_CLR = 1'b1
) (
  input logic         clk,
  input logic         clr_n,
  input logic         load_n,
  input logic [W-1:0] preset,
  input logic         cnt_en,
  input logic         carry_en,
  input logic [W-1:0] count,
  input logic         carry_out
);

  localparam logic [W-1:0] TERM_V = DECADE ? W'(9) : {W{1'b1}};

  generate
    if (ASYNC_CLR) begin : g_ac
      p_async_clear_r1: assert property (@(posedge clk) !clr_n |-> count == '0)
        else $error("R1 async clear not zero");
    end else begin : g_sc
      p_sync_clear_r2: assert property (@(posedge clk) !clr_n |=> count == '0)
        else $error("R2 sync clear not zero after edge");
    end
  endgenerate

  p_load_r3: assert property (@(posedge clk) disable iff (!clr_n)
    !load_n |=> count == $past(preset))
    else $error("R3 load mismatch");

  p_step_r4: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && cnt_en && carry_en && count != TERM_V) |=> count == $past(count) + W'(1))
    else $error("R4 step mismatch");

  p_hold_r5: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && !(cnt_en && carry_en)) |=> $stable(count))
    else $error("R5 hold mismatch");

  p_wrap_r6: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && cnt_en && carry_en && count == TERM_V) |=> count == '0)
    else $error("R6 wrap mismatch");

  p_carry_r7: assert property (@(posedge clk) disable iff (!clr_n)
    carry_out |-> (carry_en && count == TERM_V))
    else $error("R7 carry without terminal");

endmodule

bind presettable_counter presettable_counter_chk #(
  .W(W), .DECADE(DECADE), .ASYNC_CLR(ASYNC_CLR)
) u_chk (
  .clk(clk), .clr_n(clr_n), .load_n(load_n), .preset(preset),
  .cnt_en(cnt_en), .carry_en(carry_en), .count(count), .carry_out(carry_out)
);

// File: tb/tb_presettable_counter.sv
module tb_presettable_counter;

  logic       clk = 1'b0;
  logic       clr_n = 1'b0;
  logic       load_n = 1'b1;
  logic [3:0] preset = 4'd0;
  logic       cnt_en = 1'b0;
  logic       carry_en = 1'b0;
  logic [3:0] cnt_dec, cnt_bin;
  logic       co_dec, co_bin;

  always #2.5 clk = ~clk;

  // Decade, immediate clear
  presettable_counter #(.W(4), .DECADE(1'b1), .ASYNC_CLR(1'b1)) dut (
    .clk(clk), .clr_n(clr_n), .load_n(load_n), .preset(preset),
    .cnt_en(cnt_en), .carry_en(carry_en), .count(cnt_dec), .carry_out(co_dec)
  );

  // Binary, edge-timed clear
  presettable_counter #(.W(4), .DECADE(1'b0), .ASYNC_CLR(1'b0)) dut_bin (
    .clk(clk), .clr_n(clr_n), .load_n(load_n), .preset(preset),
    .cnt_en(cnt_en), .carry_en(carry_en), .count(cnt_bin), .carry_out(co_bin)
  );

  typedef struct packed {
    logic [3:0] dec;
    logic [3:0] bin;
    logic [7:0] tag;
  } exp_t;

  exp_t q[$];
  int   n_run  = 0;
  int   n_fail = 0;
  logic [3:0] m_dec = 4'd0;
  logic [3:0] m_bin = 4'd0;
  bit   primed = 1'b0;

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [3:0] nxt(input logic [3:0] v, input int unsigned term);
    return (v == 4'(term)) ? 4'd0 : v + 4'd1;
  endfunction

  // Driver: apply one cycle of stimulus, check pre-edge behaviour, push expected.
  task automatic step(input logic c, input logic ld, input logic [3:0] p,
                      input logic pe, input logic te, input logic [7:0] tag);
    exp_t e;
    @(negedge clk);
    clr_n = c; load_n = ld; preset = p; cnt_en = pe; carry_en = te;
    #1;
    // R7: carry follows its inputs before the edge
    chk("R7 carry decade", {3'd0, co_dec}, {3'd0, te & c & (m_dec == 4'd9)});
    if (primed) chk("R7 carry binary", {3'd0, co_bin}, {3'd0, te & (m_bin == 4'd15)});
    if (!c) begin
      chk("R1 immediate clear", cnt_dec, 4'd0);
      if (primed) chk("R2 clear waits for edge", cnt_bin, m_bin);
    end
    if (!c) begin
      m_dec = 4'd0; m_bin = 4'd0;
    end else if (!ld) begin
      m_dec = p; m_bin = p;
    end else if (pe && te) begin
      m_dec = nxt(m_dec, 9); m_bin = nxt(m_bin, 15);
    end
    e.dec = m_dec; e.bin = m_bin; e.tag = tag;
    q.push_back(e);
    primed = 1'b1;
  endtask

  // Monitor: compare after each edge.
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      string rq;
      e = q.pop_front();
      rq = $sformatf("R%0d", e.tag);
      chk({rq, " decade count"}, cnt_dec, e.dec);
      chk({rq, " binary count"}, cnt_bin, e.bin);
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    // reset state (R1/R2)
    step(1'b0, 1'b1, 4'd0, 1'b0, 1'b0, 8'd2);
    step(1'b0, 1'b1, 4'd0, 1'b1, 1'b1, 8'd2);
    // R4 / R6: count through decade wrap
    for (int i = 0; i < 12; i++) step(1'b1, 1'b1, 4'd0, 1'b1, 1'b1, 8'd4);
    // R5: hold with each enable low
    step(1'b1, 1'b1, 4'd0, 1'b0, 1'b1, 8'd5);
    step(1'b1, 1'b1, 4'd0, 1'b1, 1'b0, 8'd5);
    // R3: load with enables low, then with enables high
    step(1'b1, 1'b0, 4'd9, 1'b0, 1'b0, 8'd3);
    // R7: at 9 with cnt_en low, carry_en high -> decade carry, hold
    step(1'b1, 1'b1, 4'd0, 1'b0, 1'b1, 8'd7);
    step(1'b1, 1'b0, 4'd5, 1'b1, 1'b1, 8'd3);
    // R8 / R6: preset 13 and count through 15
    step(1'b1, 1'b0, 4'd13, 1'b0, 1'b0, 8'd8);
    for (int i = 0; i < 4; i++) step(1'b1, 1'b1, 4'd0, 1'b1, 1'b1, 8'd8);
    // R6: binary hold at 15 with carry_en high shows carry
    step(1'b1, 1'b0, 4'd15, 1'b0, 1'b0, 8'd6);
    step(1'b1, 1'b1, 4'd0, 1'b0, 1'b1, 8'd6);
    step(1'b1, 1'b1, 4'd0, 1'b1, 1'b1, 8'd6);
    // R2 / R1: clear together with load overrides load
    step(1'b1, 1'b0, 4'd7, 1'b0, 1'b0, 8'd3);
    step(1'b0, 1'b0, 4'd11, 1'b1, 1'b1, 8'd2);
    step(1'b1, 1'b1, 4'd0, 1'b1, 1'b1, 8'd4);
    repeat (3) @(posedge clk);
    #2;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule